// File: doc/BRIEF.md
# Control-Period Real-Time Integrity Monitor

This block watches the processor against the hard real-time control schedule. A period tick opens each control period. The processor must end the task it started before the next tick comes. It must also hand its output data to the logic within every period. A broken rule sets one of two latched software faults: an overrun fault for a late task, and a delivery watchdog fault for missing data. Both faults feed one combined line, and the fault manager uses that line as an immediate protection-trip request.

These faults cannot be recovered in the normal way. A normal fault acknowledge has no effect on them. Only a restart pulse, given when the user code is relaunched, clears them. After reset or restart the monitor stays quiet until the processor starts its first task. This keeps a fault from being reported before the schedule has begun to run. All pins are single-cycle control pulses or plain status levels. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `rt_integrity_guard`

## Requirements
- R1: The monitor sets `ovr_flag` when a tick arrives while armed and while a task is pending, that is, after a `task_begin` with no `task_end` since. The flag is visible from the cycle after the tick. A `task_end` in the tick's own cycle counts as finished in time.
- R2: The monitor sets `wdg_flag` when a tick arrives while armed and no `data_rx` pulse was seen in the period that the tick closes. That period runs from the cycle after the previous tick up to and including the tick's own cycle. The flag is visible from the cycle after the tick. A `data_rx` in the tick cycle counts only for the period that ends there.
- R3: Once set, either flag stays set over any later ticks, task pulses or data pulses. The `fault_ack` input has no effect on the flags at all.
- R4: A `restart` pulse clears both flags from the next cycle and disarms the monitor. Restart takes priority over a `task_begin`, `task_end`, `data_rx` or tick in the same cycle.
- R5: After reset or restart, no fault is raised until the first `task_begin`. Ticks before that point report nothing, even with no data delivered.
- R6: A `task_end` pulse with no pending task is ignored. It does not make the next task count as finished early, and it never causes an overrun.
- R7: `sw_fault` is high exactly when `ovr_flag` or `wdg_flag` is high, in the same cycle.
- R8: While `rst_n` is low, all three outputs are low. This holds even if a reset arrives while a fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_tick | input | 1 | One-cycle pulse that closes one control period and opens the next |
| task_begin | input | 1 | Processor has started its control task |
| task_end | input | 1 | Processor has finished its control task |
| data_rx | input | 1 | Processor output data has been received by the logic |
| fault_ack | input | 1 | Normal fault acknowledge; has no effect on these faults |
| restart | input | 1 | User-code restart; the only way to clear the faults |
| ovr_flag | output | 1 | Latched overrun fault |
| wdg_flag | output | 1 | Latched delivery watchdog fault |
| sw_fault | output | 1 | Combined unrecoverable fault / trip request |

## Verification
The hardest cases to reach from the ports are coincident pulses: a tick in the same cycle as `task_end` or `data_rx`, and a restart that lands together with `task_begin`. The stimulus table drives these as single cycles with several inputs high at once. Each one follows a sequence that leaves the monitor armed and holding a known period history, so the outcome of the shared cycle decides the result. A stray `task_end` is placed between a completed task and the next tick to show that it has no effect.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // one bit per unrecoverable cause, index fixed so the latch vector maps to ports
  localparam int CAUSE_N = 2;
  typedef enum int {
    CAUSE_OVERRUN  = 0,
    CAUSE_DELIVERY = 1
  } cause_e;
  typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/rtg_arm.sv
module rtg_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic task_begin,
  input  logic restart,
  output logic armed
);
  logic armed_q;

  // arming waits for the first task start; restart drops it again
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (restart)    armed_q <= 1'b0;
    else if (task_begin) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  // R4
  disarm_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !armed_q);
endmodule

// File: rtl/rtg_overrun.sv
module rtg_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic period_tick,
  input  logic task_begin,
  input  logic task_end,
  input  logic restart,
  output logic hit
);
  logic busy_q;

  // a stray end while idle leaves busy_q untouched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (restart)    busy_q <= 1'b0;
    else if (task_begin) busy_q <= 1'b1;
    else if (task_end)   busy_q <= 1'b0;
  end

  // finishing in the tick cycle is still on time
  assign hit = armed & period_tick & busy_q & ~task_end & ~restart;

  // R6
  stray_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_end && !busy_q && !task_begin) |=> !busy_q);
endmodule

// File: rtl/rtg_delivery.sv
module rtg_delivery (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic period_tick,
  input  logic data_rx,
  input  logic restart,
  output logic hit
);
  logic got_q;

  // the flag covers exactly one period; data seen on the tick belongs to the closing one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           got_q <= 1'b0;
    else if (restart)     got_q <= 1'b0;
    else if (period_tick) got_q <= 1'b0;
    else if (data_rx)     got_q <= 1'b1;
  end

  assign hit = armed & period_tick & ~got_q & ~data_rx & ~restart;

  // R2
  period_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !got_q);
endmodule

// File: rtl/rtg_latch.sv
module rtg_latch
  import rtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t hit,
  input  logic       restart,
  output cause_vec_t flags
);
  cause_vec_t flag_q;

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (restart) flag_q[i] <= 1'b0;
      else if (hit[i])  flag_q[i] <= 1'b1;
    end

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !restart) |=> flag_q[i]);

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !flag_q[i]);
  end

  assign flags = flag_q;
endmodule

// File: rtl/rt_integrity_guard.sv
module rt_integrity_guard
  import rtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic period_tick,
  input  logic task_begin,
  input  logic task_end,
  input  logic data_rx,
  input  logic fault_ack,
  input  logic restart,
  output logic ovr_flag,
  output logic wdg_flag,
  output logic sw_fault
);
  logic       armed;
  cause_vec_t hit;
  cause_vec_t flags;
  logic       ack_unused;

  // these faults are beyond acknowledge; the pin exists only to prove that
  assign ack_unused = fault_ack;

  rtg_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .task_begin (task_begin),
    .restart    (restart),
    .armed      (armed)
  );

  rtg_overrun u_ovr (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .period_tick (period_tick),
    .task_begin  (task_begin),
    .task_end    (task_end),
    .restart     (restart),
    .hit         (hit[CAUSE_OVERRUN])
  );

  rtg_delivery u_dly (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .period_tick (period_tick),
    .data_rx     (data_rx),
    .restart     (restart),
    .hit         (hit[CAUSE_DELIVERY])
  );

  rtg_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .restart (restart),
    .flags   (flags)
  );

  assign ovr_flag = flags[CAUSE_OVERRUN];
  assign wdg_flag = flags[CAUSE_DELIVERY];
  assign sw_fault = |flags;

  // R5
  quiet_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (hit == '0));

  // R1
  ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[CAUSE_OVERRUN] |=> ovr_flag);

  // R2
  wdg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[CAUSE_DELIVERY] |=> wdg_flag);

  // R3
  ack_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_unused && sw_fault && !restart) |=> sw_fault);
endmodule

// File: tb/sim_rt_integrity_guard.sv
module sim_rt_integrity_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0, task_begin = 1'b0, task_end = 1'b0;
  logic data_rx = 1'b0, fault_ack = 1'b0, restart = 1'b0;
  logic ovr_flag, wdg_flag, sw_fault;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rt_integrity_guard u0 (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .task_begin(task_begin),
    .task_end(task_end), .data_rx(data_rx), .fault_ack(fault_ack), .restart(restart),
    .ovr_flag(ovr_flag), .wdg_flag(wdg_flag), .sw_fault(sw_fault)
  );

  // {tick, begin, end, data, ack, restart, exp_ovr, exp_wdg}; expected is after that cycle
  localparam int NV = 32;
  localparam logic [7:0] VEC [NV] = '{
    8'b000000_00, 8'b100000_00, 8'b010000_00, 8'b000100_00,
    8'b001000_00, 8'b100000_00, 8'b010000_00, 8'b001000_00,
    8'b001000_00, 8'b000100_00, 8'b100000_00, 8'b010000_00,
    8'b000100_00, 8'b100000_10, 8'b001000_10, 8'b000010_10,
    8'b100000_11, 8'b000010_11, 8'b000001_00, 8'b100000_00,
    8'b010000_00, 8'b100000_11, 8'b000001_00, 8'b010000_00,
    8'b000100_00, 8'b101000_00, 8'b100100_00, 8'b100000_01,
    8'b010001_00, 8'b100000_00, 8'b010000_00, 8'b101100_00
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at a falling edge, hold one cycle, return at the next falling edge
  task automatic cyc(input logic [5:0] in);
    {period_tick, task_begin, task_end, data_rx, fault_ack, restart} = in;
    @(negedge clk);
    {period_tick, task_begin, task_end, data_rx, fault_ack, restart} = 6'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 outputs low in reset
    chk("R8 ovr in reset", ovr_flag, 1'b0);
    chk("R8 wdg in reset", wdg_flag, 1'b0);
    chk("R8 sw in reset", sw_fault, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][7:2]);
      chk("R1 ovr vector", ovr_flag, VEC[i][1]);
      chk("R2 wdg vector", wdg_flag, VEC[i][0]);
      chk("R7 combined vector", sw_fault, VEC[i][1] | VEC[i][0]);
    end

    // R5: fresh restart, ticks with no data and no task start stay silent
    cyc(6'b000001);
    for (int k = 0; k < 4; k++) cyc(6'b100000);
    chk("R5 no ovr before first start", ovr_flag, 1'b0);
    chk("R5 no wdg before first start", wdg_flag, 1'b0);

    // R6: stray end before a start must not pre-finish the task
    cyc(6'b001000);
    cyc(6'b010000);
    cyc(6'b000100);
    cyc(6'b100000);
    chk("R6 stray end then late task -> overrun", ovr_flag, 1'b1);
    chk("R6 data given -> no watchdog", wdg_flag, 1'b0);

    // R3: acknowledge and further traffic leave the fault set
    for (int k = 0; k < 5; k++) cyc(6'b000010);
    cyc(6'b101110);
    chk("R3 ovr survives ack", ovr_flag, 1'b1);
    chk("R3 sw survives ack", sw_fault, 1'b1);

    // R4: restart alongside begin and end wins, and leaves the monitor disarmed
    cyc(6'b111101);
    chk("R4 restart clears ovr", ovr_flag, 1'b0);
    chk("R4 restart clears sw", sw_fault, 1'b0);
    cyc(6'b100000);
    cyc(6'b100000);
    chk("R4 disarmed after restart", sw_fault, 1'b0);

    // R8: reset while a fault is latched
    cyc(6'b010000);
    cyc(6'b100000);
    chk("R8 precondition fault", sw_fault, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear ovr", ovr_flag, 1'b0);
    chk("R8 async clear wdg", wdg_flag, 1'b0);
    chk("R8 async clear sw", sw_fault, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(6'b100000);
    chk("R8 not armed after reset", sw_fault, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule